// File: doc/BRIEF.md
# MDIO Management Clock Generator

This block derives the management data clock (MDC) for an MDIO serial management port from the system clock. A 3-bit select picks one of eight fixed division ratios, some of them not powers of two. MDC toggles only while a management read or write is in progress, which a `busy` input signals. When there is no transaction, MDC rests low.

Alongside MDC the block gives single-cycle strobes that mark its rising and falling edges. The serial shift engine that builds the management frame uses these strobes to launch and capture bits. The high and low phases are always of equal length. A new select value is sampled only at the end of a low phase, so a period never stretches or shrinks halfway through. The ratio should be chosen so that MDC stays at or below 2.5 MHz for the given system clock.

Top module: `mdc_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `mdc`, `mdc_rise` and `mdc_fall` are all 0. The divisor latched at reset is that of code 3'b010 (divide by 32).
- R2: While `busy` is low and no MDC period is in progress, `mdc` stays 0 and neither strobe pulses.
- R3: `div_sel` picks the total MDC period in system clocks: 3'b000=8, 3'b001=16, 3'b010=32, 3'b011=48, 3'b100=64, 3'b101=96, 3'b110=128, 3'b111=224.
- R4: Every MDC period has exactly half of the selected count high and the other half low.
- R5: `mdc_rise` is 1 for exactly the first cycle in which `mdc` is 1, and `mdc_fall` is 1 for exactly the first cycle in which `mdc` is 0 after a high phase. The two strobes never pulse together.
- R6: When `busy` is seen high at a clock edge while the block is idle, `mdc` is 1 in the cycle after that edge.
- R7: A `div_sel` change made during a period has no effect until that period's low phase ends. The next period uses the new value.
- R8: When `busy` falls, the current high phase and the low phase after it complete at full length. `mdc` then stays 0.
- R9: While `busy` stays high, periods follow one another with no idle gap: the next rise comes right after a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div_sel | input | 3 | Division ratio select code |
| busy | input | 1 | A management transaction is in progress |
| mdc | output | 1 | Management data clock |
| mdc_rise | output | 1 | One-cycle strobe in the first high cycle of MDC |
| mdc_fall | output | 1 | One-cycle strobe in the first low cycle of MDC |

## Verification
The hardest case to reach from the ports is a select change that arrives in the middle of a running period. The old ratio must still govern both the rest of the high phase and the whole low phase after it. The stimulus starts a divide-by-8 transaction and switches the select to the largest ratio in the first high cycle. It then measures the remaining high run, the low run that follows, and the next high run separately. A busy drop in the first cycle of a high phase is applied for every table entry, to show that both phases still complete and that MDC then rests low.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 7;

  // Half-period (cycles per MDC phase) for each select code.
  function automatic logic [CNT_W-1:0] half_of(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] h;
    case (sel)
      3'd0:    h = 7'd4;
      3'd1:    h = 7'd8;
      3'd2:    h = 7'd16;
      3'd3:    h = 7'd24;
      3'd4:    h = 7'd32;
      3'd5:    h = 7'd48;
      3'd6:    h = 7'd64;
      default: h = 7'd112;
    endcase
    return h;
  endfunction

  function automatic logic is_half(input logic [CNT_W-1:0] n);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (half_of(SEL_W'(i)) == n) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/mdc_half_lut.sv
module mdc_half_lut
  import mdc_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] half
);
  always_comb begin
    half = half_of(sel);
  end
endmodule

// File: rtl/mdc_phase_cnt.sv
module mdc_phase_cnt
  import mdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val - CNT_W'(1);
    else if (dec) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/mdc_gen.sv
module mdc_gen
  import mdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             busy,
  output logic             mdc,
  output logic             mdc_rise,
  output logic             mdc_fall
);
  localparam logic [SEL_W-1:0] RST_SEL = 3'b010;

  logic [CNT_W-1:0] lut_half;
  logic [CNT_W-1:0] half_q, half_d;
  logic [CNT_W-1:0] load_val;
  logic             mdc_q, mdc_d, rise_q, rise_d, fall_q, fall_d;
  logic             phase_end, load, dec, half_en;

  mdc_half_lut u_lut (
    .sel  (div_sel),
    .half (lut_half)
  );

  mdc_phase_cnt u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .dec      (dec),
    .load_val (load_val),
    .zero     (phase_end)
  );

  // Next-state: select is sampled only at the end of a low phase or while idle.
  always_comb begin
    mdc_d    = mdc_q;
    rise_d   = 1'b0;
    fall_d   = 1'b0;
    load     = 1'b0;
    dec      = 1'b0;
    load_val = half_q;
    half_d   = half_q;
    half_en  = 1'b0;
    if (!phase_end) begin
      dec = 1'b1;
    end else if (mdc_q) begin
      mdc_d    = 1'b0;
      fall_d   = 1'b1;
      load     = 1'b1;
      load_val = half_q;
    end else begin
      half_d  = lut_half;
      half_en = 1'b1;
      if (busy) begin
        mdc_d    = 1'b1;
        rise_d   = 1'b1;
        load     = 1'b1;
        load_val = lut_half;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      mdc_q  <= mdc_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= half_of(RST_SEL);
    else if (half_en) half_q <= half_d;
  end

  assign mdc      = mdc_q;
  assign mdc_rise = rise_q;
  assign mdc_fall = fall_q;
endmodule

// File: rtl/mdc_gen_chk.sv
module mdc_gen_chk
  import mdc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic mdc,
  input logic mdc_rise,
  input logic mdc_fall
);
  logic [CNT_W-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_run <= '0;
    else if (mdc) hi_run <= hi_run + CNT_W'(1);
    else          hi_run <= '0;
  end

  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdc && !busy) |=> !mdc);

  a_r5_rise_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_rise |-> $rose(mdc));

  a_r5_edge_has_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> mdc_rise);

  a_r5_fall_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_fall |-> $fell(mdc));

  a_r5_edge_has_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> mdc_fall);

  a_r5_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(mdc_rise && mdc_fall));

  a_r4_high_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> is_half(hi_run));
endmodule

bind mdc_gen mdc_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .mdc      (mdc),
  .mdc_rise (mdc_rise),
  .mdc_fall (mdc_fall)
);

// File: tb/sim_mdc_gen.sv
module sim_mdc_gen;
  logic       clk;
  logic       rst_n;
  logic [2:0] div_sel;
  logic       busy;
  logic       mdc, mdc_rise, mdc_fall;
  int         n_chk;
  int         n_err;

  localparam int DIVS [8] = '{8, 16, 32, 48, 64, 96, 128, 224};

  mdc_gen u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_sel  (div_sel),
    .busy     (busy),
    .mdc      (mdc),
    .mdc_rise (mdc_rise),
    .mdc_fall (mdc_fall)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count consecutive negedge samples where mdc equals v.
  task automatic run_len(input logic v, output int n);
    n = 0;
    while (mdc == v && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int hi, lo, seen;
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    busy = 1'b0;
    div_sel = 3'd0;
    repeat (3) @(negedge clk);
    check("R1 mdc in reset", mdc, 0);
    check("R1 strobes in reset", mdc_rise | mdc_fall, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mdc after release", mdc, 0);

    // R2: idle with busy low
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      seen |= mdc | mdc_rise | mdc_fall;
    end
    check("R2 idle activity", seen, 0);

    // Table walk: R3, R4, R5, R6, R8, R9
    for (int i = 0; i < 8; i++) begin
      div_sel = 3'(i);
      busy = 1'b1;
      @(negedge clk);
      check("R6 start next cycle", mdc, 1);
      check("R5 rise strobe", mdc_rise, 1);
      run_len(1'b1, hi);
      check("R5 fall strobe", mdc_fall, 1);
      run_len(1'b0, lo);
      check("R3 R4 high phase", hi, DIVS[i] / 2);
      check("R3 R4 low phase", lo, DIVS[i] / 2);
      check("R9 back-to-back rise", mdc_rise, 1);
      busy = 1'b0;
      run_len(1'b1, hi);
      check("R8 high completes", hi, DIVS[i] / 2);
      seen = 0;
      for (int k = 0; k < DIVS[i] * 2; k++) begin
        if (mdc_rise) seen++;
        @(negedge clk);
      end
      check("R8 rests low", mdc, 0);
      check("R8 no rise after busy drop", seen, 0);
    end

    // R7: select change in the middle of a period
    div_sel = 3'd0;
    busy = 1'b1;
    @(negedge clk);
    check("R7 start", mdc, 1);
    div_sel = 3'd7;
    run_len(1'b1, hi);
    run_len(1'b0, lo);
    check("R7 old high kept", hi, 4);
    check("R7 old low kept", lo, 4);
    busy = 1'b0;
    run_len(1'b1, hi);
    check("R7 new ratio applied", hi, 112);
    run_len(1'b0, lo);
    check("R7 R8 new low then rest", lo, 1000);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule